// File: doc/BRIEF.md
# Dual-Mode DRAM Command Router

This block connects one memory-controller command port to two 16-bit PHY slices. A static mode input selects how the slices are used. In the two-channel mode (LPDDR4), every accepted command is copied to both slices in the same cycle, so the two x16 channels run in lockstep. A two-tick command on a 6-bit command/address bus carries up to 12 bits, and each 32-byte channel access becomes a 64-byte transfer. In the single-channel mode (LPDDR3), both slices together form one x32 channel. Commands go only to slice 0 and are limited to the 10-bit command/address width. Slice 1 is disabled and shows a fixed no-operation code.

Each command carries its burst length, and the router compares it with the length the current mode requires: 16 beats in two-channel mode and 8 beats in single-channel mode. A command with the wrong length is consumed, not forwarded, and flagged. The mode may change only while nothing is pending in a slice. A change that arrives while a command is still waiting in a slice drops that command and raises a separate flag. Each slice holds one command until its PHY accepts it, using a valid/ready handshake.

Top module: `dmr_cmd_router`

## Requirements
- R1: During and right after reset, both slice valids and both error flags are low. The registered mode is the two-channel mode (value 0), so both slice enables are high.
- R2: In two-channel mode (registered mode 0), a command accepted with a correct burst appears on both slices one cycle after acceptance. Both slices show the same full CMD_W-bit value.
- R3: In single-channel mode (registered mode 1), an accepted command with a correct burst appears only on slice 0, one cycle after acceptance. Its bits at positions CA3_W and above are forced to zero.
- R4: In single-channel mode, slice 1 valid stays low and slice 1 command equals NOP_CMD.
- R5: mc_ready is high exactly when three things hold: the mode input equals the registered mode, slice 0 is empty or its ready is high, and, in two-channel mode only, slice 1 is empty or its ready is high. In single-channel mode, slice 1 ready has no effect.
- R6: A slice holding a command whose ready is low keeps its valid high and its command unchanged.
- R7: The required burst length is BL_LP4 (16) in two-channel mode and BL_LP3 (8) in single-channel mode. An accepted command whose mc_burst differs from the required length is not forwarded to any slice, and err_burst is high for exactly the following cycle.
- R8: In a cycle where mode_lp3 differs from the registered mode, mc_ready and both slice valids are low. Any command held in a slice is discarded. err_mode is high in the next cycle if a command was discarded. The registered mode takes the input's value at that clock edge.
- R9: slice0_en is always high, and slice1_en is high only in two-channel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_lp3 | input | 1 | 0 = two x16 lockstep channels, 1 = single x32 channel |
| mc_valid | input | 1 | Controller command valid |
| mc_ready | output | 1 | Router can accept a command |
| mc_cmd | input | CMD_W | Controller command word |
| mc_burst | input | BL_W | Burst length of the access, in beats |
| slice0_valid | output | 1 | Command valid toward slice 0 |
| slice0_ready | input | 1 | Slice 0 accepts its command |
| slice0_cmd | output | CMD_W | Command toward slice 0 |
| slice1_valid | output | 1 | Command valid toward slice 1 |
| slice1_ready | input | 1 | Slice 1 accepts its command |
| slice1_cmd | output | CMD_W | Command toward slice 1 |
| slice0_en | output | 1 | Slice 0 in use |
| slice1_en | output | 1 | Slice 1 in use |
| err_burst | output | 1 | One-cycle flag: wrong burst length for the mode |
| err_mode | output | 1 | One-cycle flag: mode change discarded a pending command |

## Verification
The bench builds the router with its default parameters: a 12-bit command, a 10-bit single-channel width, burst lengths 16 and 8, and a NOP code of 0x00F. Because the command is wider than the single-channel width, the all-ones command shows the top two bits cleared in one mode and kept in the other. Because the NOP code is non-zero, it cannot be confused with a reset value. With these values, the bench exercises lockstep replication, stalls on either slice, wrong bursts in both modes, and a mode change both when the slices are idle and when a command is held.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    typedef enum logic {
        MODE_DUAL16   = 1'b0,
        MODE_SINGLE32 = 1'b1
    } mode_e;

    typedef struct packed {
        logic mode;
        logic err_burst;
        logic err_mode;
    } ctl_t;
endpackage

// File: rtl/dmr_burst_chk.sv
module dmr_burst_chk #(
    parameter int BL_W   = 5,
    parameter int BL_LP4 = 16,
    parameter int BL_LP3 = 8
) (
    input  logic            single_i,
    input  logic [BL_W-1:0] burst_i,
    output logic            ok_o
);
    localparam logic [BL_W-1:0] LenDual   = BL_W'(BL_LP4);
    localparam logic [BL_W-1:0] LenSingle = BL_W'(BL_LP3);

    always_comb begin
        ok_o = (burst_i == (single_i ? LenSingle : LenDual));
    end
endmodule

// File: rtl/dmr_slice_reg.sv
module dmr_slice_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         flush_i,
    input  logic [W-1:0] din_i,
    input  logic         ready_i,
    output logic         vld_o,
    output logic [W-1:0] dout_o,
    output logic         free_o
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (flush_i) begin
            slot_d.vld = 1'b0;
        end else if (load_i) begin
            slot_d.vld  = 1'b1;
            slot_d.data = din_i;
        end else if (ready_i) begin
            slot_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign vld_o  = slot_q.vld;
    assign dout_o = slot_q.data;
    assign free_o = !slot_q.vld || ready_i;

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.vld && !ready_i && !flush_i) |=> (slot_q.vld && $stable(slot_q.data)));
endmodule

// File: rtl/dmr_cmd_router.sv
module dmr_cmd_router
    import dmr_pkg::*;
#(
    parameter int              CMD_W   = 12,
    parameter int              CA3_W   = 10,
    parameter int              BL_W    = 5,
    parameter int              BL_LP4  = 16,
    parameter int              BL_LP3  = 8,
    parameter logic [CMD_W-1:0] NOP_CMD = 12'h00F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_lp3,
    input  logic             mc_valid,
    output logic             mc_ready,
    input  logic [CMD_W-1:0] mc_cmd,
    input  logic [BL_W-1:0]  mc_burst,
    output logic             slice0_valid,
    input  logic             slice0_ready,
    output logic [CMD_W-1:0] slice0_cmd,
    output logic             slice1_valid,
    input  logic             slice1_ready,
    output logic [CMD_W-1:0] slice1_cmd,
    output logic             slice0_en,
    output logic             slice1_en,
    output logic             err_burst,
    output logic             err_mode
);
    localparam int NSLICE = 2;
    localparam logic [CMD_W-1:0] SingleMask = CMD_W'((1 << CA3_W) - 1);

    ctl_t ctl_d, ctl_q;

    logic                 mode_chg, burst_ok, accept;
    logic [CMD_W-1:0]     cmd_fwd;
    logic [NSLICE-1:0]    slc_load, slc_vld, slc_free, slc_ready;
    logic [CMD_W-1:0]     slc_dout [NSLICE];

    assign slc_ready = {slice1_ready, slice0_ready};

    dmr_burst_chk #(.BL_W(BL_W), .BL_LP4(BL_LP4), .BL_LP3(BL_LP3)) i_bchk (
        .single_i (ctl_q.mode),
        .burst_i  (mc_burst),
        .ok_o     (burst_ok)
    );

    always_comb begin
        mode_chg = (mode_lp3 != ctl_q.mode);
        mc_ready = !mode_chg && slc_free[0] && (ctl_q.mode || slc_free[1]);
        accept   = mc_valid && mc_ready;
        cmd_fwd  = ctl_q.mode ? (mc_cmd & SingleMask) : mc_cmd;
        slc_load[0] = accept && burst_ok;
        slc_load[1] = accept && burst_ok && (ctl_q.mode == MODE_DUAL16);

        ctl_d           = ctl_q;
        ctl_d.mode      = mode_lp3;
        ctl_d.err_burst = accept && !burst_ok;
        ctl_d.err_mode  = mode_chg && (|slc_vld);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        dmr_slice_reg #(.W(CMD_W)) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (slc_load[s]),
            .flush_i (mode_chg),
            .din_i   (cmd_fwd),
            .ready_i (slc_ready[s]),
            .vld_o   (slc_vld[s]),
            .dout_o  (slc_dout[s]),
            .free_o  (slc_free[s])
        );
    end

    assign slice0_valid = slc_vld[0] && !mode_chg;
    assign slice0_cmd   = slc_dout[0];
    assign slice1_valid = slc_vld[1] && !mode_chg && (ctl_q.mode == MODE_DUAL16);
    assign slice1_cmd   = ctl_q.mode ? NOP_CMD : slc_dout[1];
    assign slice0_en    = 1'b1;
    assign slice1_en    = (ctl_q.mode == MODE_DUAL16);
    assign err_burst    = ctl_q.err_burst;
    assign err_mode     = ctl_q.err_mode;

    assert_lockstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && burst_ok && !ctl_q.mode) |=> (slc_vld[1] && slc_dout[1] == slc_dout[0]));

    assert_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode && slice0_valid) |-> ((slice0_cmd & ~SingleMask) == '0));

    assert_idle_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode && $past(ctl_q.mode)) |-> !slc_vld[1]);

    assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mc_ready |-> slc_free[0]);

    assert_burst_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_valid && mc_ready && !burst_ok) |=> (err_burst && !slc_vld[0]));

    assert_mode_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (!mc_ready && !slice0_valid && !slice1_valid));

    assert_mode_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_chg && (|slc_vld)) |=> (err_mode && slc_vld == '0));
endmodule

// File: tb/test_dmr_cmd_router.sv
module test_dmr_cmd_router;
    localparam int CMD_W = 12;
    localparam int BL_W  = 5;
    localparam logic [CMD_W-1:0] NOP = 12'h00F;
    localparam logic [CMD_W-1:0] MASK3 = 12'h3FF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_lp3 = 1'b0, mc_valid = 1'b0, mc_ready;
    logic [CMD_W-1:0] mc_cmd = '0;
    logic [BL_W-1:0]  mc_burst = '0;
    logic s0_valid, s0_ready = 1'b1, s1_valid, s1_ready = 1'b1;
    logic [CMD_W-1:0] s0_cmd, s1_cmd;
    logic s0_en, s1_en, err_burst, err_mode;

    int errors = 0, checks = 0;
    bit done = 0;

    // reference state
    bit m_mode, m_v0, m_v1, m_eb, m_em;
    logic [CMD_W-1:0] m_c0, m_c1;

    always #5 clk = ~clk;

    dmr_cmd_router i_dmr_cmd_router (
        .clk(clk), .rst_n(rst_n), .mode_lp3(mode_lp3),
        .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_cmd(mc_cmd), .mc_burst(mc_burst),
        .slice0_valid(s0_valid), .slice0_ready(s0_ready), .slice0_cmd(s0_cmd),
        .slice1_valid(s1_valid), .slice1_ready(s1_ready), .slice1_cmd(s1_cmd),
        .slice0_en(s0_en), .slice1_en(s1_en), .err_burst(err_burst), .err_mode(err_mode)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        bit chg, rdy, acc, blok;
        logic [CMD_W-1:0] fwd;
        #1;
        chg = (mode_lp3 != m_mode);
        rdy = !chg && (!m_v0 || s0_ready) && (m_mode || !m_v1 || s1_ready);
        chk(mc_ready === rdy, "R5", mc_ready, rdy);
        chk(s0_valid === (m_v0 && !chg), m_mode ? "R3" : "R2", s0_valid, m_v0 && !chg);
        chk(s0_cmd === m_c0, m_mode ? "R3" : "R2", s0_cmd, m_c0);
        chk(s1_valid === (!m_mode && m_v1 && !chg), m_mode ? "R4" : "R2", s1_valid, !m_mode && m_v1 && !chg);
        chk(s1_cmd === (m_mode ? NOP : m_c1), m_mode ? "R4" : "R2", s1_cmd, m_mode ? NOP : m_c1);
        chk(s0_en === 1'b1 && s1_en === !m_mode, "R9", {s0_en, s1_en}, {1'b1, !m_mode});
        chk(err_burst === m_eb, "R7", err_burst, m_eb);
        chk(err_mode === m_em, "R8", err_mode, m_em);
        @(posedge clk);
        if (!rst_n) begin
            m_mode = 0; m_v0 = 0; m_v1 = 0; m_eb = 0; m_em = 0; m_c0 = '0; m_c1 = '0;
        end else begin
            acc  = mc_valid && rdy;
            blok = (mc_burst == (m_mode ? 5'd8 : 5'd16));
            fwd  = m_mode ? (mc_cmd & MASK3) : mc_cmd;
            m_em = chg && (m_v0 || m_v1);
            m_eb = acc && !blok;
            if (chg) m_v0 = 0;
            else if (acc && blok) begin m_v0 = 1; m_c0 = fwd; end
            else if (s0_ready) m_v0 = 0;
            if (chg) m_v1 = 0;
            else if (acc && blok && !m_mode) begin m_v1 = 1; m_c1 = fwd; end
            else if (s1_ready) m_v1 = 0;
            m_mode = mode_lp3;
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [CMD_W-1:0] c, input int bl);
        mc_valid = 1; mc_cmd = c; mc_burst = BL_W'(bl);
        step();
        mc_valid = 0;
    endtask

    initial begin
        m_mode = 0; m_v0 = 0; m_v1 = 0; m_eb = 0; m_em = 0; m_c0 = '0; m_c1 = '0;
        @(negedge clk);
        // R1: reset state
        repeat (3) step();
        chk(!s0_valid && !s1_valid && !err_burst && !err_mode, "R1", {s0_valid, s1_valid}, 0);
        chk(s0_en && s1_en, "R1", {s0_en, s1_en}, 2'b11);
        rst_n = 1;
        step();
        // R2: lockstep in two-channel mode
        send(12'hABC, 16); step();
        send(12'hFFF, 16); send(12'h123, 16); step();
        // R6/R5: stall slice 1
        s1_ready = 0;
        send(12'h5A5, 16);
        send(12'h777, 16);
        repeat (3) step();
        chk(s1_valid && s1_cmd == 12'h5A5, "R6", s1_cmd, 12'h5A5);
        s1_ready = 1; step(); step();
        // R7: wrong burst in two-channel mode
        send(12'h0F0, 8); step();
        // R8: idle mode change to single-channel
        mode_lp3 = 1; step(); step();
        // R3/R4: single-channel, slice 1 ready ignored
        s1_ready = 0;
        send(12'hFFF, 8); step();
        send(12'hC01, 8); step();
        chk(s1_cmd == NOP && !s1_valid, "R4", s1_cmd, NOP);
        // R7: wrong burst in single-channel mode
        send(12'h111, 16); step();
        // R8: mode change with pending command
        s1_ready = 1; s0_ready = 0;
        send(12'h222, 8);
        step();
        mode_lp3 = 0; step();
        chk(err_mode == 1'b1, "R8", err_mode, 1);
        step();
        s0_ready = 1;
        send(12'h333, 16); step();
        repeat (2) step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule